// File: doc/BRIEF.md
# Byte-Wide Link Quad-Word Transmitter

This block sends 128-bit words across a byte-wide, source-clocked link. The system clock runs at twice the link rate. The outgoing strobe is produced by toggling a register once per system cycle, and one byte goes out on every strobe transition. A word therefore occupies sixteen system cycles, or eight link cycles. A parallel word is offered on a valid/ready pair. Before the first word of a burst, the block pulls its strobe low as a transfer request and lets a fixed interval pass. It then starts only if the receiver's handshake line is high.

The receiver uses the handshake line to pace the link. If the line falls while a word is on the wire, that word still completes, but the following word is held back. The block then parks with the strobe low and waits for the line to return. If the line returns inside a short window, the next word starts at once. Otherwise the block drops back to idle with the strobe high, and the next word needs a fresh request. An optional check byte, the XOR of the sixteen data bytes, can follow each word on one extra strobe transition.

Top module: `lp_quad_tx`

## Requirements
- R1: While the asynchronous active-low reset is asserted, the strobe is high, the byte-valid flag is low and the input ready is low, whatever the other inputs do.
- R2: In idle the strobe rests high. When a word is offered from idle and the handshake line is steadily high, the strobe goes low for exactly 12 system cycles (6 link cycles), and the first byte then appears.
- R3: The handshake input passes through a two-stage synchronizer. If it is low when the request interval ends, the strobe stays low and no byte is sent until it has been seen high.
- R4: A word goes out as 16 bytes on 16 consecutive cycles, least significant byte (bits [7:0]) first. The strobe toggles on every byte cycle, and the first byte after any gap goes out on a rising strobe.
- R5: If the handshake stays high for a whole word and another word is offered by its last byte cycle, the next word follows on the very next cycle with no gap.
- R6: If the handshake is seen low during a word, that word completes, but the next one is not started on the following cycle. The strobe is held low while the block waits. If the handshake returns within 12 cycles, the next word starts directly, with no high strobe and no fresh request.
- R7: If the 12-cycle wait window runs out, the strobe returns high for at least one cycle. The next word then goes through a full request.
- R8: With the check enable high, each word carries a 17th byte on one more strobe transition, equal to the XOR of its 16 data bytes. With the enable low, no such byte is sent.
- R9: A word is taken on a cycle where valid and ready are both high. Its first byte is on the link in the next cycle, and no byte is ever sent without an accepted word.
- R10: After the last byte, if no word is pending, the strobe returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the link rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Append the XOR check byte to each word |
| word_i | input | 128 | Word to transmit |
| word_valid_i | input | 1 | Word on word_i is offered |
| word_ready_o | output | 1 | Word is taken this cycle |
| hs_i | input | 1 | Receiver handshake, high when it can take a word |
| stb_o | output | 1 | Outgoing link strobe |
| byte_o | output | 8 | Outgoing link byte |
| byte_vld_o | output | 1 | A data or check byte is on the link this cycle |

## Verification
The hardest situation to produce from the ports is the wait between words. To reach it, the handshake must be seen low inside a word after the two synchronizer cycles, and must then return either inside or outside the 12-cycle window. The bench watches byte-valid, drops the handshake a few cycles into a word and raises it again after a chosen delay. It then measures the gap, the low-strobe stretch and any high strobe between the two words. A random phase toggles the handshake every cycle against a stream of words, and every byte received is compared with the expected byte stream.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_HOLD = 2'd3
  } lp_state_e;

endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl
  import lp_pkg::*;
#(
  parameter int QUAD_BYTES = 16,
  parameter int REQ_CYC    = 12,
  parameter int WIN_CYC    = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_en,
  input  logic valid_i,
  input  logic hs_s,
  output logic accept_o,
  output logic adv_o,
  output logic chk_o,
  output logic stb_o,
  output logic vld_o
);

  localparam int IDX_W   = $clog2(QUAD_BYTES + 1);
  localparam int CNT_MAX = (REQ_CYC > WIN_CYC) ? REQ_CYC : WIN_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  lp_state_e        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             low_q, low_n;
  logic             stb_q, stb_n;
  logic             vld_q, vld_n;
  logic             last_data;
  logic             last_byte;
  logic             accept;

  assign last_data = (idx_q == IDX_W'(QUAD_BYTES - 1));
  assign last_byte = (last_data && !chk_en) || (idx_q == IDX_W'(QUAD_BYTES));

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    low_n  = low_q;
    stb_n  = stb_q;
    vld_n  = 1'b0;
    accept = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        stb_n = 1'b1;
        if (valid_i) begin
          st_n  = ST_REQ;
          cnt_n = '0;
          stb_n = 1'b0;
        end
      end
      ST_REQ: begin
        stb_n = 1'b0;
        if (cnt_q == CNT_W'(REQ_CYC - 1)) begin
          if (hs_s && valid_i) accept = 1'b1;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      ST_XFER: begin
        low_n = low_q | ~hs_s;
        if (last_byte) begin
          if (valid_i && hs_s && !low_q) begin
            accept = 1'b1;
          end else if (!valid_i) begin
            st_n  = ST_IDLE;
            stb_n = 1'b1;
          end else begin
            st_n  = ST_HOLD;
            cnt_n = '0;
            stb_n = 1'b0;
          end
        end else begin
          idx_n = idx_q + IDX_W'(1);
          stb_n = ~stb_q;
          vld_n = 1'b1;
        end
      end
      ST_HOLD: begin
        stb_n = 1'b0;
        if (hs_s && valid_i) begin
          accept = 1'b1;
        end else if (hs_s || (cnt_q == CNT_W'(WIN_CYC - 1))) begin
          st_n  = ST_IDLE;
          stb_n = 1'b1;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (accept) begin
      st_n  = ST_XFER;
      idx_n = '0;
      low_n = 1'b0;
      stb_n = ~stb_q;
      vld_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      low_q <= 1'b0;
      stb_q <= 1'b1;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      idx_q <= idx_n;
      low_q <= low_n;
      stb_q <= stb_n;
      vld_q <= vld_n;
    end
  end

  assign accept_o = accept;
  assign adv_o    = (st_q == ST_XFER) && !last_byte && !last_data && !accept;
  assign chk_o    = (st_q == ST_XFER) && last_data && chk_en && !accept;
  assign stb_o    = stb_q;
  assign vld_o    = vld_q;

endmodule

// File: rtl/lp_dpath.sv
module lp_dpath #(
  parameter int BYTE_W     = 8,
  parameter int QUAD_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [BYTE_W*QUAD_BYTES-1:0] word_i,
  input  logic                         load_i,
  input  logic                         adv_i,
  input  logic                         chk_i,
  output logic [BYTE_W-1:0]            byte_o
);

  localparam int WORD_W = BYTE_W * QUAD_BYTES;

  logic [WORD_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] par_q, par_n;
  logic [BYTE_W-1:0] dat_q, dat_n;
  logic              en;

  function automatic logic [BYTE_W-1:0] fold(input logic [WORD_W-1:0] w);
    logic [BYTE_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < QUAD_BYTES; i++) begin
      acc = acc ^ w[i*BYTE_W +: BYTE_W];
    end
    return acc;
  endfunction

  assign en = load_i | adv_i | chk_i;

  always_comb begin
    sh_n  = sh_q;
    par_n = par_q;
    dat_n = dat_q;
    if (load_i) begin
      sh_n  = word_i;
      par_n = fold(word_i);
      dat_n = word_i[BYTE_W-1:0];
    end else if (adv_i) begin
      sh_n  = sh_q >> BYTE_W;
      dat_n = sh_q[2*BYTE_W-1 -: BYTE_W];
    end else if (chk_i) begin
      dat_n = par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      par_q <= '0;
      dat_q <= '0;
    end else if (en) begin
      sh_q  <= sh_n;
      par_q <= par_n;
      dat_q <= dat_n;
    end
  end

  assign byte_o = dat_q;

endmodule

// File: rtl/lp_quad_tx.sv
module lp_quad_tx #(
  parameter int BYTE_W      = 8,
  parameter int QUAD_BYTES  = 16,
  parameter int REQ_CYC     = 12,
  parameter int WIN_CYC     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         chk_en,
  input  logic [BYTE_W*QUAD_BYTES-1:0] word_i,
  input  logic                         word_valid_i,
  output logic                         word_ready_o,
  input  logic                         hs_i,
  output logic                         stb_o,
  output logic [BYTE_W-1:0]            byte_o,
  output logic                         byte_vld_o
);

  logic hs_s;
  logic accept;
  logic adv;
  logic chk;

  lp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (hs_i),
    .q     (hs_s)
  );

  lp_ctrl #(
    .QUAD_BYTES (QUAD_BYTES),
    .REQ_CYC    (REQ_CYC),
    .WIN_CYC    (WIN_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_en   (chk_en),
    .valid_i  (word_valid_i),
    .hs_s     (hs_s),
    .accept_o (accept),
    .adv_o    (adv),
    .chk_o    (chk),
    .stb_o    (stb_o),
    .vld_o    (byte_vld_o)
  );

  lp_dpath #(
    .BYTE_W     (BYTE_W),
    .QUAD_BYTES (QUAD_BYTES)
  ) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .word_i (word_i),
    .load_i (accept),
    .adv_i  (adv),
    .chk_i  (chk),
    .byte_o (byte_o)
  );

  assign word_ready_o = accept;

endmodule

// File: rtl/lp_quad_tx_chk.sv
module lp_quad_tx_chk #(
  parameter int BYTE_W     = 8,
  parameter int QUAD_BYTES = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         chk_en,
  input logic [BYTE_W*QUAD_BYTES-1:0] word_i,
  input logic                         word_valid_i,
  input logic                         word_ready_o,
  input logic                         stb_o,
  input logic [BYTE_W-1:0]            byte_o,
  input logic                         byte_vld_o
);

  localparam int WORD_W = BYTE_W * QUAD_BYTES;
  localparam int K_W    = $clog2(QUAD_BYTES + 2);

  logic [WORD_W-1:0] exp_w;
  logic [K_W-1:0]    k;
  logic [BYTE_W-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_w <= '0;
      k     <= K_W'(QUAD_BYTES + 1);
      acc   <= '0;
    end else if (word_valid_i && word_ready_o) begin
      exp_w <= word_i;
      k     <= '0;
      acc   <= '0;
    end else if (byte_vld_o) begin
      k     <= k + K_W'(1);
      acc   <= acc ^ byte_o;
    end
  end

  a_r4_byte_order: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_o && (k < K_W'(QUAD_BYTES))) |-> (byte_o == exp_w[int'(k)*BYTE_W +: BYTE_W]));

  a_r8_check_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_o && (k == K_W'(QUAD_BYTES))) |-> (chk_en && (byte_o == acc)));

  a_r9_no_extra_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> (k <= K_W'(QUAD_BYTES)));

  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_o && $past(byte_vld_o)) |-> (stb_o != $past(stb_o)));

  a_r4_rise_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_vld_o) |-> stb_o);

  a_r9_ready_then_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_i && word_ready_o) |=> byte_vld_o);

endmodule

bind lp_quad_tx lp_quad_tx_chk #(
  .BYTE_W     (BYTE_W),
  .QUAD_BYTES (QUAD_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chk_en       (chk_en),
  .word_i       (word_i),
  .word_valid_i (word_valid_i),
  .word_ready_o (word_ready_o),
  .stb_o        (stb_o),
  .byte_o       (byte_o),
  .byte_vld_o   (byte_vld_o)
);

// File: tb/lp_quad_tx_test.sv
module lp_quad_tx_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         chk_en;
  logic [127:0] wd;
  logic         vld;
  logic         rdy;
  logic         hs;
  logic         stb;
  logic [7:0]   bt;
  logic         bv;

  always #2 clk = ~clk;

  lp_quad_tx uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_en       (chk_en),
    .word_i       (wd),
    .word_valid_i (vld),
    .word_ready_o (rdy),
    .hs_i         (hs),
    .stb_o        (stb),
    .byte_o       (bt),
    .byte_vld_o   (bv)
  );

  int checks = 0;
  int errors = 0;
  int mchecks = 0;
  int merrors = 0;

  logic [7:0] rx_mem [0:4095];
  int         rx_n = 0;
  logic [7:0] exp_mem [0:4095];
  int         exp_tag [0:4095];
  int         exp_n = 0;
  int         rd = 0;

  int run = 0, gap = 0, lo = 0, hi = 0;
  int last_run = 0, last_gap = 0, last_lo = 0, last_hi = 0;
  logic prev_stb = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bv) begin
        mchecks++;
        if (run == 0) begin
          last_gap = gap; last_lo = lo; last_hi = hi;
          if (stb != 1'b1) begin
            merrors++;
            $display("FAIL R4 first byte strobe actual=%0d expected=1", stb);
          end
        end else if (stb == prev_stb) begin
          merrors++;
          $display("FAIL R4 strobe toggle actual=%0d expected=%0d", stb, !prev_stb);
        end
        if (rx_n < 4096) rx_mem[rx_n] = bt;
        rx_n++;
        run++;
        prev_stb = stb;
      end else begin
        if (run > 0) begin
          last_run = run; run = 0; gap = 0; lo = 0; hi = 0;
        end
        gap++;
        if (stb) begin hi = 1; lo = 0; end else lo++;
      end
    end
  end

  function automatic logic [7:0] xfold(input logic [127:0] w);
    logic [7:0] a = 8'h00;
    for (int i = 0; i < 16; i++) a = a ^ w[8*i +: 8];
    return a;
  endfunction

  task automatic push(input logic [127:0] w);
    for (int i = 0; i < 16; i++) begin
      exp_mem[exp_n] = w[8*i +: 8]; exp_tag[exp_n] = 4; exp_n++;
    end
    if (chk_en) begin
      exp_mem[exp_n] = xfold(w); exp_tag[exp_n] = 8; exp_n++;
    end
    wd = w; vld = 1'b1;
    #1;
    while (!rdy) begin @(negedge clk); #1; end
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic drain();
    while (rx_n < exp_n) @(negedge clk);
    repeat (4) @(negedge clk);
    for (int i = rd; i < exp_n; i++) begin
      if (exp_tag[i] == 8)
        check(rx_mem[i] == exp_mem[i], "R8", "check byte", rx_mem[i], exp_mem[i]);
      else
        check(rx_mem[i] == exp_mem[i], "R4", "data byte", rx_mem[i], exp_mem[i]);
    end
    rd = exp_n;
    check(rx_n == exp_n, "R9", "byte count", rx_n, exp_n);
  endtask

  task automatic rnd_word(output logic [127:0] w);
    w = {$urandom, $urandom, $urandom, $urandom};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrors + 1);
    $finish;
  end

  initial begin
    logic [127:0] w1, w2;
    bit rand_on;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; chk_en = 1'b0; vld = 1'b1; hs = 1'b1;
    wd = '1;
    repeat (4) @(negedge clk);
    check(stb == 1'b1, "R1", "strobe in reset", stb, 1);
    check(bv == 1'b0, "R1", "byte valid in reset", bv, 0);
    check(rdy == 1'b0, "R1", "ready in reset", rdy, 0);
    vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(stb == 1'b1, "R2", "idle strobe", stb, 1);

    // R2 / R10: request length from idle, single word
    push(128'h0f0e0d0c0b0a09080706050403020100);
    drain();
    check(last_lo == 12, "R2", "request low cycles", last_lo, 12);
    check(last_hi == 1, "R2", "idle high before request", last_hi, 1);
    check(last_run == 16, "R4", "bytes per word", last_run, 16);
    check(stb == 1'b1, "R10", "strobe high after finish", stb, 1);

    // R5: back-to-back words
    push('0);
    push('1);
    drain();
    check(last_run == 32, "R5", "contiguous run", last_run, 32);

    // R6: handshake dips inside a word, returns before the word ends
    rnd_word(w1); rnd_word(w2);
    fork
      begin push(w1); push(w2); end
      begin
        while (!bv) @(negedge clk);
        repeat (3) @(negedge clk); hs = 1'b0;
        repeat (3) @(negedge clk); hs = 1'b1;
      end
    join
    drain();
    check(last_gap == 1, "R6", "gap after dip", last_gap, 1);
    check(last_hi == 0, "R6", "no high strobe in gap", last_hi, 0);

    // R6: handshake low past word end, returns inside window
    rnd_word(w1); rnd_word(w2);
    fork
      begin push(w1); push(w2); end
      begin
        while (!bv) @(negedge clk);
        repeat (3) @(negedge clk); hs = 1'b0;
        while (bv) @(negedge clk);
        repeat (4) @(negedge clk); hs = 1'b1;
      end
    join
    drain();
    check(last_hi == 0, "R6", "strobe low through wait", last_hi, 0);
    check(last_gap >= 4 && last_gap <= 12, "R6", "resume inside window", last_gap, 7);

    // R7: window expires
    rnd_word(w1); rnd_word(w2);
    fork
      begin push(w1); push(w2); end
      begin
        while (!bv) @(negedge clk);
        repeat (3) @(negedge clk); hs = 1'b0;
        while (bv) @(negedge clk);
        repeat (40) @(negedge clk); hs = 1'b1;
      end
    join
    drain();
    check(last_hi == 1, "R7", "strobe high after expiry", last_hi, 1);
    check(last_lo >= 12, "R7", "fresh request low stretch", last_lo, 12);
    check(last_gap > 25, "R7", "no early resume", last_gap, 26);

    // R3: handshake low when request interval ends
    hs = 1'b0;
    repeat (6) @(negedge clk);
    rnd_word(w1);
    fork
      push(w1);
      begin repeat (30) @(negedge clk); hs = 1'b1; end
    join
    drain();
    check(last_lo >= 30, "R3", "held until handshake high", last_lo, 30);
    check(last_run == 16, "R3", "word after wait", last_run, 16);

    // R8: check byte, single and back-to-back
    chk_en = 1'b1;
    push('1);
    drain();
    check(last_run == 17, "R8", "run with check byte", last_run, 17);
    rnd_word(w1); rnd_word(w2);
    push(w1); push(w2);
    drain();
    check(last_run == 34, "R8", "back-to-back with check", last_run, 34);

    // Random phase: random handshake, both check settings
    for (int ph = 0; ph < 2; ph++) begin
      chk_en = ph[0];
      rand_on = 1'b1;
      fork
        begin
          for (int n = 0; n < 12; n++) begin
            rnd_word(w1);
            if (n == 3) w1 = 128'haaaa5555aaaa5555aaaa5555aaaa5555;
            push(w1);
          end
          rand_on = 1'b0;
        end
        begin
          while (rand_on) begin
            @(negedge clk);
            hs = (($urandom % 10) < 6);
          end
        end
      join
      hs = 1'b1;
      drain();
    end

    repeat (20) @(negedge clk);
    check(rx_n == exp_n, "R9", "no stray bytes", rx_n, exp_n);
    check(stb == 1'b1, "R10", "final idle strobe", stb, 1);

    $display("  CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrors);
    $finish;
  end

endmodule